// File: doc/BRIEF.md
# UART Baud Tick Generator

This block turns a fixed system clock into the two timing strobes that an asynchronous serial port needs. A reference enable, pulsing at forty-eight times the 1 MBaud unit rate (so forty-eight million strobes per second), drives a reload counter. Each time that counter expires, the block emits a one-cycle oversample tick, at sixteen times the serial bit rate, which paces receive-line sampling. Every sixteenth oversample tick also raises a one-cycle bit tick that paces the transmitter.

Software sets the rate with a 16-bit divisor, written as two byte-wide register writes. The bit rate is 3,000,000 divided by the divisor. Two divisor values are reserved as fast codes. Code 0 gives 3 MBaud, with one oversample tick per reference strobe. Code 1 gives 2 MBaud, with one tick per one and a half reference strobes on average. No other setting reaches a rate above 1.5 MBaud. A new divisor is staged and switched in only at a counter expiry, so a rate change never cuts a tick period short.

Top module: `uart_baud_gen`

## Requirements
- R1: After reset the divisor is code 0, the counters are cleared, and both tick outputs are low.
- R2: For a divisor D of 2 or more, `os_tick` pulses for one cycle once in every D reference strobes.
- R3: Divisor code 0 gives one `os_tick` pulse for every reference strobe.
- R4: Divisor code 1 gives `os_tick` gaps that alternate between one and two reference strobes, so each consecutive pair of gaps spans exactly three strobes.
- R5: `bit_tick` is high exactly on every sixteenth `os_tick` pulse, counted from reset (the 16th, 32nd and so on), and never on any other cycle.
- R6: A high-byte write (`wr_hi`) only stages bits 15:8 of the divisor. The rate does not change until a low-byte write (`wr_lo`) supplies bits 7:0 and commits the full 16-bit value.
- R7: A committed divisor first applies at the next counter expiry. The tick period already in progress finishes at its old length.
- R8: `os_tick` is high only in the clock cycle that follows a clock edge at which `ref_en` was high.
- R9: While `rst_n` is low, neither tick output is asserted, whatever `ref_en` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_en | input | 1 | Reference strobe at 48 times the 1 MBaud unit rate |
| wr_hi | input | 1 | Write strobe: stage `wr_data` as divisor bits 15:8 |
| wr_lo | input | 1 | Write strobe: commit `wr_data` as bits 7:0 together with the staged high byte |
| wr_data | input | 8 | Byte written by either strobe |
| os_tick | output | 1 | One-cycle pulse at sixteen times the bit rate |
| bit_tick | output | 1 | One-cycle pulse at the bit rate, aligned to an `os_tick` |

## Verification
The bench sweeps divisors 0, 1, 2, several small odd and even values and 1000, with the reference strobe on every cycle and also on every third cycle. It checks every tick gap against the arithmetic period. A counter that treated code 0 or 1 as a plain divide value would show gaps of zero or one strobe, and a broken half-step carry would make code 1 drift away from its three-strobe pair sum. The bench changes the divisor in the middle of a long period. A design that reloaded straight away would emit a short runt gap, and one that committed on the high byte alone would change rate one write too early. Bit ticks are matched against a count of oversample ticks from reset, which catches an off-by-one divide-by-sixteen.

// File: rtl/uart_brg_pkg.sv
// Shared constants and types for the baud tick generator.
// Assumes the counter works in half reference steps, so that the
// 2 MBaud code can use an average reload of one and a half strobes.
package uart_brg_pkg;
    // Half-steps consumed by each reference strobe.
    localparam int HALF_PER_REF = 2;
    // Reload, in half-steps, for the two reserved fast codes.
    localparam int FAST0_HALF   = 2;   // 3 MBaud: 1 strobe
    localparam int FAST1_HALF   = 3;   // 2 MBaud: 1.5 strobes
    // Rate class of a divisor value.
    typedef enum logic [1:0] {
        RATE_FAST0 = 2'd0,
        RATE_FAST1 = 2'd1,
        RATE_PLAIN = 2'd2
    } rate_class_e;
endpackage

// File: rtl/brg_div_regs.sv
// Divisor register pair. A high-byte write stages the upper byte. A
// low-byte write commits the full value as pending. The pending value
// becomes active when the counter reports an expiry (take).
// Assumes wr_hi and wr_lo may arrive in any cycle, including the
// expiry cycle. A commit in the expiry cycle stays pending.
module brg_div_regs #(
    parameter int DIV_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              take,
    output logic [DIV_W-1:0]  div_next
);
    localparam int HI_W = DIV_W - BYTE_W;

    logic [HI_W-1:0]  hi_stage;
    logic [DIV_W-1:0] pend_val;
    logic             pend;
    logic [DIV_W-1:0] div_act;

    // Capture the staged upper byte.
    always_ff @(posedge clk) begin
        if (!rst_n) hi_stage <= '0;
        else if (wr_hi) hi_stage <= wr_data[HI_W-1:0];
    end

    // Commit on a low-byte write; a fresh commit wins over a take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend     <= 1'b0;
            pend_val <= '0;
        end else if (wr_lo) begin
            pend     <= 1'b1;
            pend_val <= {hi_stage, wr_data};
        end else if (take) begin
            pend     <= 1'b0;
        end
    end

    // Active divisor follows the value used at each expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) div_act <= '0;
        else if (take) div_act <= div_next;
    end

    // Value the counter reloads with at its next expiry.
    always_comb div_next = pend ? pend_val : div_act;

    // R7: a pending commit is consumed by an expiry without a new write.
    p_pend_consumed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !wr_lo) |=> !pend);
    // R7: the active divisor moves only at an expiry.
    p_act_only_on_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(div_act));
    // R6: a high-byte write alone never creates a pending commit.
    p_hi_alone_no_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !wr_lo && !pend) |=> !pend);
endmodule

// File: rtl/brg_frac_counter.sv
// Oversample reload counter. It counts remaining half reference steps.
// Each ref_en removes two half-steps. When two or fewer remain, the
// counter expires, emits take, and reloads. The leftover half-step is
// carried into the reload, which gives code 1 its 1.5-strobe average.
// Assumes div_in is stable in the cycle that take is high.
module brg_frac_counter
    import uart_brg_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_en,
    input  logic [DIV_W-1:0] div_in,
    output logic             take,
    output logic             os_tick
);
    localparam int CW = DIV_W + 1;
    localparam logic [CW-1:0] STEP = CW'(HALF_PER_REF);

    rate_class_e     rate;
    logic [CW-1:0]   reload;
    logic [CW-1:0]   cnt;

    // Classify the divisor and pick its reload in half-steps.
    always_comb begin
        if (div_in == '0)                 rate = RATE_FAST0;
        else if (div_in == DIV_W'(1))     rate = RATE_FAST1;
        else                              rate = RATE_PLAIN;
        case (rate)
            RATE_FAST0: reload = CW'(FAST0_HALF);
            RATE_FAST1: reload = CW'(FAST1_HALF);
            default:    reload = {div_in, 1'b0};
        endcase
    end

    // Expiry when this strobe uses up the remaining half-steps.
    always_comb take = ref_en && (cnt <= STEP);

    // Count down, reload at expiry, and carry any leftover half-step.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= CW'(FAST0_HALF);
        else if (take)   cnt <= reload - (STEP - cnt);
        else if (ref_en) cnt <= cnt - STEP;
    end

    // Registered one-cycle oversample strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) os_tick <= 1'b0;
        else        os_tick <= take;
    end

    // R8: an oversample tick always follows an edge that saw ref_en.
    p_os_after_ref_r8: assert property (@(posedge clk) disable iff (!rst_n)
        os_tick |-> $past(ref_en));
    // R2: the half-step count never empties, so no strobe is lost.
    p_cnt_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt != '0);
    // R2: without a strobe the count holds.
    p_cnt_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_en |=> $stable(cnt));
endmodule

// File: rtl/brg_bit_div.sv
// Divides the oversample expiry by the oversampling ratio. The bit
// strobe is registered in the same cycle as every ratio-th oversample
// strobe. Assumes os_in is the unregistered expiry from the counter.
module brg_bit_div #(
    parameter int OS_RATIO = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic os_in,
    output logic bit_tick
);
    localparam int PW = $clog2(OS_RATIO);
    localparam logic [PW-1:0] LAST = PW'(OS_RATIO - 1);

    logic [PW-1:0] phase;
    logic          wrap;

    // Last oversample of the bit period.
    always_comb wrap = os_in && (phase == LAST);

    // Advance the phase on every oversample expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)     phase <= '0;
        else if (wrap)  phase <= '0;
        else if (os_in) phase <= phase + PW'(1);
    end

    // Registered bit strobe, aligned with the registered oversample.
    always_ff @(posedge clk) begin
        if (!rst_n) bit_tick <= 1'b0;
        else        bit_tick <= wrap;
    end

    // R5: the phase holds between oversample strobes.
    p_phase_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !os_in |=> $stable(phase));
    // R5: two bit strobes are never adjacent.
    p_bit_isolated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> !bit_tick);
endmodule

// File: rtl/uart_baud_gen.sv
// Baud tick generator top. Joins the divisor registers, the
// oversample reload counter and the divide-by-ratio stage.
// Assumes ref_en is a one-cycle strobe at 48x the 1 MBaud unit rate,
// synchronous to clk.
module uart_baud_gen #(
    parameter int DIV_W    = 16,
    parameter int OS_RATIO = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ref_en,
    input  logic                 wr_hi,
    input  logic                 wr_lo,
    input  logic [DIV_W/2-1:0]   wr_data,
    output logic                 os_tick,
    output logic                 bit_tick
);
    localparam int BYTE_W = DIV_W / 2;

    logic [DIV_W-1:0] div_next;
    logic             take;

    brg_div_regs #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hi    (wr_hi),
        .wr_lo    (wr_lo),
        .wr_data  (wr_data),
        .take     (take),
        .div_next (div_next)
    );

    brg_frac_counter #(.DIV_W(DIV_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_en  (ref_en),
        .div_in  (div_next),
        .take    (take),
        .os_tick (os_tick)
    );

    brg_bit_div #(.OS_RATIO(OS_RATIO)) u_bit (
        .clk      (clk),
        .rst_n    (rst_n),
        .os_in    (take),
        .bit_tick (bit_tick)
    );

    // R9: a reset edge leaves both outputs low (checked during reset).
    p_quiet_in_reset_r9: assert property (@(posedge clk)
        !rst_n |=> (!os_tick && !bit_tick));
    // R5: a bit strobe only appears together with an oversample strobe.
    p_bit_on_os_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_tick);
endmodule

// File: tb/uart_baud_gen_bench.sv
`timescale 1ns/1ps
module uart_baud_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_en = 1'b0;
    logic       wr_hi = 1'b0;
    logic       wr_lo = 1'b0;
    logic [7:0] wr_data = '0;
    logic       os_tick;
    logic       bit_tick;

    int checks = 0;
    int errors = 0;
    int ref_p = 1;
    int ref_phase = 0;
    int r8_bad = 0;
    bit done = 1'b0;

    uart_baud_gen u_uart_baud_gen (
        .clk(clk), .rst_n(rst_n), .ref_en(ref_en),
        .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
        .os_tick(os_tick), .bit_tick(bit_tick)
    );

    always #10 clk = ~clk;   // 50 MHz

    // Reference strobe driver and R8 monitor, both at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && os_tick && !ref_en) r8_bad++;
            ref_phase = (ref_phase + 1 >= ref_p) ? 0 : ref_phase + 1;
            ref_en = (ref_phase == 0);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count falling edges until the next one that sees os_tick high.
    task automatic next_os(output int cyc);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!os_tick);
    endtask

    task automatic program_div(input int d);
        @(negedge clk); wr_hi = 1'b1; wr_data = 8'((d >> 8) & 8'hFF);
        @(negedge clk); wr_hi = 1'b0; wr_lo = 1'b1; wr_data = 8'(d & 8'hFF);
        @(negedge clk); wr_lo = 1'b0;
    endtask

    // Program a plain or code-0 divisor and check several gaps (R2, R3).
    task automatic sweep_plain(input int d, input int p, input string req);
        int g;
        int eff;
        ref_p = p;
        program_div(d);
        next_os(g); next_os(g); next_os(g);
        eff = (d == 0) ? 1 : d;
        for (int k = 0; k < 5; k++) begin
            next_os(g);
            check(g == eff * p, req, g, eff * p);
        end
    endtask

    // Code 1: gaps of 1 or 2 strobes, each pair summing to 3 (R4).
    task automatic sweep_code1(input int p);
        int g1;
        int g2;
        ref_p = p;
        program_div(1);
        next_os(g1); next_os(g1); next_os(g1);
        for (int k = 0; k < 4; k++) begin
            next_os(g1);
            next_os(g2);
            check((g1 == p || g1 == 2 * p) && (g2 == p || g2 == 2 * p),
                  "R4 gap size", g1 * 100 + g2, p);
            check(g1 + g2 == 3 * p, "R4 pair sum", g1 + g2, 3 * p);
        end
    endtask

    initial begin
        int g;
        int hits;
        int acc;
        // Reset with the strobe running: R9 and R1.
        hits = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (os_tick || bit_tick) hits++;
        end
        check(hits == 0, "R9 ticks during reset", hits, 0);
        check(!os_tick && !bit_tick, "R1 outputs low at reset",
              int'(os_tick) + int'(bit_tick), 0);
        rst_n = 1'b1;

        // Default code 0 after reset; bit tick on every 16th (R1, R3, R5).
        for (int k = 1; k <= 64; k++) begin
            next_os(g);
            if (k > 1) check(g == 1, "R1 default code 0 gap", g, 1);
            check(bit_tick == (k % 16 == 0), "R5 bit alignment",
                  int'(bit_tick), int'(k % 16 == 0));
        end

        // Plain divisors and fast codes at two strobe rates.
        sweep_plain(2, 1, "R2 d=2");
        sweep_plain(3, 1, "R2 d=3");
        sweep_plain(7, 1, "R2 d=7");
        sweep_plain(16, 1, "R2 d=16");
        sweep_plain(1000, 1, "R2 d=1000");
        sweep_plain(2, 3, "R2 d=2 p=3");
        sweep_plain(9, 3, "R2 d=9 p=3");
        sweep_plain(0, 3, "R3 code 0 p=3");
        sweep_plain(0, 1, "R3 code 0 p=1");
        sweep_code1(1);
        sweep_code1(2);

        // High byte alone leaves the rate alone; low byte commits (R6).
        sweep_plain(5, 1, "R6 base d=5");
        @(negedge clk); wr_hi = 1'b1; wr_data = 8'h01;
        @(negedge clk); wr_hi = 1'b0;
        next_os(g); next_os(g);
        for (int k = 0; k < 4; k++) begin
            next_os(g);
            check(g == 5, "R6 high byte alone", g, 5);
        end
        @(negedge clk); wr_lo = 1'b1; wr_data = 8'h00;
        @(negedge clk); wr_lo = 1'b0;
        next_os(g); next_os(g);
        for (int k = 0; k < 3; k++) begin
            next_os(g);
            check(g == 256, "R6 commit on low byte", g, 256);
        end

        // Mid-period change: old period finishes, then new (R7).
        sweep_plain(40, 1, "R7 base d=40");
        next_os(g);
        acc = 0;
        for (int i = 0; i < 10; i++) begin @(negedge clk); acc++; end
        program_div(3);
        acc += 3;
        next_os(g);
        check(acc + g == 40, "R7 no runt", acc + g, 40);
        next_os(g);
        check(g == 3, "R7 new divisor after expiry", g, 3);

        check(r8_bad == 0, "R8 tick without strobe", r8_bad, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule